// File: doc/BRIEF.md
# Mailbox Receive Window Bank

This block sits on the receiving side of an inter-processor mailbox. It holds a parameterised number of 32-bit channel windows. Each window keeps a status word, a mask word and a masked view of the status. A sender-side link sets status bits with single-cycle pulses. Software reaches the bank through a simple word-addressed register port. Through that port it reads status, clears status bits by writing ones, and sets or clears mask bits by writing ones.

Every window contributes one bit to a summary vector. That bit is high while the window has any unmasked pending bit. The summary is readable as four 32-bit words, so a handler can find the firing window without scanning each window in turn. One interrupt line combines the whole summary, gated by an enable bit. A handler reads the summary, reads the window's status and clears it. The interrupt then falls on the following cycle.

Top module: `mbx_rx_bank`

## Requirements
- R1: After reset every status word reads 0, every mask word reads 0xFFFFFFFF, the enable register at 0xF98 reads 0 and `irq` is low.
- R2: A one on bit b of `link_set` window w sets status bit b of window w on that clock edge, whatever the mask. Status bits are never set any other way.
- R3: Writing to offset 0x08 of a window clears the status bits written as one. Zero bits leave status unchanged, and status bits never fall without such a write.
- R4: Writing ones to offset 0x14 sets mask bits and writing ones to offset 0x18 clears them. Zero bits have no effect. The mask reads back at offset 0x10 and does not change without a write.
- R5: Offset 0x04 of a window reads status AND NOT mask. Window w occupies bytes w*0x20 to w*0x20+0x1F.
- R6: Window n's summary bit (register 0xFA0 + 4*(n/32), bit n%32, and `win_pending[n]`) is the OR of its masked status.
- R7: `irq` is high exactly when bit 2 of register 0xF98 is set and some summary bit is high. Clearing the last unmasked status bit drops `irq` after the same edge that applies the write.
- R8: When a set pulse and a status-clear write hit the same bit in the same cycle, the bit ends up set.
- R9: 0xF80 reads the number of windows in bits [6:0]. 0xFCC reads the minor revision in [3:0] and the major revision in [7:4]. 0xFC8 reads the implementer identity parameter.
- R10: Reads of unimplemented offsets return 0. These include offset 0x0C, windows at or beyond the count, and unused global addresses. Writes to them, and writes to the read-only offsets 0x00, 0x04 and 0x10, change nothing.
- R11: A read request sampled on a clock edge puts its data on `reg_rdata` after that edge. `reg_rdata` then holds until the next read, and writes do not disturb it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_set | input | NUM_WIN*32 | Set pulses from the sender link, window w in bits [w*32+31:w*32] |
| reg_en | input | 1 | Register access request this cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte address, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Combined interrupt |
| win_pending | output | NUM_WIN | Per-window summary vector |

## Verification
The assertions assume that `link_set` is zero while reset is asserted. They also assume that register addresses are word aligned and that a request is either a read or a write in a given cycle, never both. The stimulus drives all inputs on the falling edge and holds `link_set` at zero during reset. It uses only aligned addresses, and it raises a set pulse together with a clear write only in the deliberate collision cases. A behavioural model of status, mask and enable is updated on every rising edge. On every falling edge it is compared with `irq` and `win_pending`. Register reads are checked against values worked out by hand.

// File: rtl/mbx_rx_pkg.sv
package mbx_rx_pkg;
   localparam int WORD_W    = 32;
   localparam int MAX_WIN   = 124;
   localparam int SUM_WORDS = 4;
   localparam int ADDR_W    = 12;
   localparam int IEN_BIT   = 2;

   localparam logic [ADDR_W-1:0] CFG_ADDR  = 12'hF80;
   localparam logic [ADDR_W-1:0] IEN_ADDR  = 12'hF98;
   localparam logic [ADDR_W-1:0] SUM_BASE  = 12'hFA0;
   localparam logic [ADDR_W-1:0] IIDR_ADDR = 12'hFC8;
   localparam logic [ADDR_W-1:0] AIDR_ADDR = 12'hFCC;

   // word index inside a 0x20-byte window slot
   typedef enum logic [2:0] {
      SL_STAT  = 3'd0,
      SL_MSTAT = 3'd1,
      SL_SCLR  = 3'd2,
      SL_RSV3  = 3'd3,
      SL_MASK  = 3'd4,
      SL_MSET  = 3'd5,
      SL_MCLR  = 3'd6,
      SL_RSV7  = 3'd7
   } slot_reg_e;

   typedef struct packed {
      logic stat_clr;
      logic mask_set;
      logic mask_clr;
   } win_wr_t;
endpackage

// File: rtl/mbx_rx_decode.sv
module mbx_rx_decode
   import mbx_rx_pkg::*;
#(
   parameter int NUM_WIN = 4
) (
   input  logic                   acc_en,
   input  logic                   acc_we,
   input  logic [ADDR_W-1:0]      acc_addr,
   output win_wr_t [NUM_WIN-1:0]  win_wr,
   output logic                   ien_wr,
   output logic                   sel_win,
   output logic [6:0]             sel_idx,
   output slot_reg_e              sel_slot,
   output logic                   sel_cfg,
   output logic                   sel_ien,
   output logic                   sel_sum,
   output logic [1:0]             sel_sum_idx,
   output logic                   sel_iidr,
   output logic                   sel_aidr
);
   logic aligned;
   logic do_wr;

   assign aligned     = (acc_addr[1:0] == 2'b00);
   assign do_wr       = acc_en && acc_we;
   assign sel_idx     = acc_addr[11:5];
   assign sel_slot    = slot_reg_e'(acc_addr[4:2]);
   assign sel_win     = aligned && (acc_addr < CFG_ADDR) && (int'(sel_idx) < NUM_WIN);
   assign sel_cfg     = (acc_addr == CFG_ADDR);
   assign sel_ien     = (acc_addr == IEN_ADDR);
   assign sel_sum     = aligned && (acc_addr[11:4] == SUM_BASE[11:4]);
   assign sel_sum_idx = acc_addr[3:2];
   assign sel_iidr    = (acc_addr == IIDR_ADDR);
   assign sel_aidr    = (acc_addr == AIDR_ADDR);
   assign ien_wr      = do_wr && sel_ien;

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_wr
      logic hit;
      assign hit = do_wr && sel_win && (int'(sel_idx) == w);
      assign win_wr[w].stat_clr = hit && (sel_slot == SL_SCLR);
      assign win_wr[w].mask_set = hit && (sel_slot == SL_MSET);
      assign win_wr[w].mask_clr = hit && (sel_slot == SL_MCLR);
   end
endmodule

// File: rtl/mbx_rx_window.sv
module mbx_rx_window
   import mbx_rx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] set_bits,
   input  win_wr_t           wr,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] stat,
   output logic [WORD_W-1:0] mask,
   output logic [WORD_W-1:0] masked,
   output logic              pending
);
   logic [WORD_W-1:0] clr_bits;

   assign clr_bits = wr.stat_clr ? wdata : '0;

   // clear first, then OR the set pulses in: a colliding set survives
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat <= '0;
      end else begin
         stat <= (stat & ~clr_bits) | set_bits;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask <= '1;
      end else if (wr.mask_set) begin
         mask <= mask | wdata;
      end else if (wr.mask_clr) begin
         mask <= mask & ~wdata;
      end
   end

   assign masked  = stat & ~mask;
   assign pending = |masked;
endmodule

// File: rtl/mbx_rx_summary.sv
module mbx_rx_summary
   import mbx_rx_pkg::*;
#(
   parameter int NUM_WIN = 4
) (
   input  logic [NUM_WIN-1:0]                pend,
   output logic [SUM_WORDS-1:0][WORD_W-1:0]  words,
   output logic                              any
);
   for (genvar k = 0; k < SUM_WORDS; k++) begin : g_word
      for (genvar b = 0; b < WORD_W; b++) begin : g_bit
         localparam int N = k * WORD_W + b;
         if (N < NUM_WIN) begin : g_live
            assign words[k][b] = pend[N];
         end else begin : g_pad
            assign words[k][b] = 1'b0;
         end
      end
   end

   assign any = |pend;
endmodule

// File: rtl/mbx_rx_bank.sv
module mbx_rx_bank
   import mbx_rx_pkg::*;
#(
   parameter int          NUM_WIN    = 4,
   parameter logic [31:0] IMPL_ID    = 32'h0102_0A5C,
   parameter int          ARCH_MAJOR = 2,
   parameter int          ARCH_MINOR = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_WIN*32-1:0]    link_set,
   input  logic                     reg_en,
   input  logic                     reg_we,
   input  logic [11:0]              reg_addr,
   input  logic [31:0]              reg_wdata,
   output logic [31:0]              reg_rdata,
   output logic                     irq,
   output logic [NUM_WIN-1:0]       win_pending
);
   localparam int FLAT_W = NUM_WIN * WORD_W;

   if (NUM_WIN < 1 || NUM_WIN > MAX_WIN) begin : g_bad_count
      $error("mbx_rx_bank: NUM_WIN out of range");
   end
   if (ARCH_MAJOR < 0 || ARCH_MAJOR > 15 || ARCH_MINOR < 0 || ARCH_MINOR > 15) begin : g_bad_rev
      $error("mbx_rx_bank: revision field out of range");
   end

   win_wr_t [NUM_WIN-1:0]              win_wr;
   logic                               ien_wr;
   logic                               sel_win, sel_cfg, sel_ien, sel_sum, sel_iidr, sel_aidr;
   logic [6:0]                         sel_idx;
   slot_reg_e                          sel_slot;
   logic [1:0]                         sel_sum_idx;
   logic [WORD_W-1:0]                  stat_a   [NUM_WIN];
   logic [WORD_W-1:0]                  mask_a   [NUM_WIN];
   logic [WORD_W-1:0]                  masked_a [NUM_WIN];
   logic [FLAT_W-1:0]                  stat_flat, mask_flat, masked_flat;
   logic [SUM_WORDS-1:0][WORD_W-1:0]   sum_words;
   logic                               any_pend;
   logic                               ien_q;
   logic [WORD_W-1:0]                  rd_mux, rdata_q;

   mbx_rx_decode #(.NUM_WIN(NUM_WIN)) u_dec (
      .acc_en      (reg_en),
      .acc_we      (reg_we),
      .acc_addr    (reg_addr),
      .win_wr      (win_wr),
      .ien_wr      (ien_wr),
      .sel_win     (sel_win),
      .sel_idx     (sel_idx),
      .sel_slot    (sel_slot),
      .sel_cfg     (sel_cfg),
      .sel_ien     (sel_ien),
      .sel_sum     (sel_sum),
      .sel_sum_idx (sel_sum_idx),
      .sel_iidr    (sel_iidr),
      .sel_aidr    (sel_aidr)
   );

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      mbx_rx_window u_win (
         .clk      (clk),
         .rst_n    (rst_n),
         .set_bits (link_set[w*WORD_W +: WORD_W]),
         .wr       (win_wr[w]),
         .wdata    (reg_wdata),
         .stat     (stat_a[w]),
         .mask     (mask_a[w]),
         .masked   (masked_a[w]),
         .pending  (win_pending[w])
      );
      assign stat_flat[w*WORD_W +: WORD_W]   = stat_a[w];
      assign mask_flat[w*WORD_W +: WORD_W]   = mask_a[w];
      assign masked_flat[w*WORD_W +: WORD_W] = masked_a[w];
   end

   mbx_rx_summary #(.NUM_WIN(NUM_WIN)) u_sum (
      .pend  (win_pending),
      .words (sum_words),
      .any   (any_pend)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q <= 1'b0;
      end else if (ien_wr) begin
         ien_q <= reg_wdata[IEN_BIT];
      end
   end

   always_comb begin
      rd_mux = '0;
      if (sel_win) begin
         for (int i = 0; i < NUM_WIN; i++) begin
            if (int'(sel_idx) == i) begin
               case (sel_slot)
                  SL_STAT:  rd_mux = stat_a[i];
                  SL_MSTAT: rd_mux = masked_a[i];
                  SL_MASK:  rd_mux = mask_a[i];
                  default:  rd_mux = '0;
               endcase
            end
         end
      end else if (sel_cfg) begin
         rd_mux = WORD_W'(NUM_WIN);
      end else if (sel_ien) begin
         rd_mux[IEN_BIT] = ien_q;
      end else if (sel_sum) begin
         rd_mux = sum_words[sel_sum_idx];
      end else if (sel_iidr) begin
         rd_mux = IMPL_ID;
      end else if (sel_aidr) begin
         rd_mux = {24'd0, 4'(ARCH_MAJOR), 4'(ARCH_MINOR)};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (reg_en && !reg_we) begin
         rdata_q <= rd_mux;
      end
   end

   assign reg_rdata = rdata_q;
   assign irq       = ien_q && any_pend;
endmodule

// File: rtl/mbx_rx_bank_chk.sv
module mbx_rx_bank_chk #(
   parameter int NUM_WIN = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [NUM_WIN*32-1:0]   link_set,
   input logic                    reg_en,
   input logic                    reg_we,
   input logic [31:0]             reg_rdata,
   input logic                    irq,
   input logic [NUM_WIN-1:0]      win_pending,
   input logic [NUM_WIN*32-1:0]   stat_flat,
   input logic [NUM_WIN*32-1:0]   mask_flat
);
   logic live_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q <= 1'b0;
      else        live_q <= 1'b1;
   end

   // R2 R8
   set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      live_q |-> (($past(link_set) & ~stat_flat) == '0));

   // R2
   no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      live_q |-> ((stat_flat & ~$past(stat_flat) & ~$past(link_set)) == '0));

   // R3
   clear_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && !$past(reg_en && reg_we)) |-> ((~stat_flat & $past(stat_flat)) == '0));

   // R4
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && !$past(reg_en && reg_we)) |-> $stable(mask_flat));

   // R7
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (win_pending != '0));

   // R11
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && !$past(reg_en && !reg_we)) |-> $stable(reg_rdata));
endmodule

bind mbx_rx_bank mbx_rx_bank_chk #(.NUM_WIN(NUM_WIN)) u_bank_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .link_set    (link_set),
   .reg_en      (reg_en),
   .reg_we      (reg_we),
   .reg_rdata   (reg_rdata),
   .irq         (irq),
   .win_pending (win_pending),
   .stat_flat   (stat_flat),
   .mask_flat   (mask_flat)
);

// File: tb/mbx_rx_bank_bench.sv
`timescale 1ns/1ps
module mbx_rx_bank_bench;
   localparam int          NW  = 40;
   localparam logic [31:0] IID = 32'h0102_0A5C;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NW*32-1:0]  link_set = '0;
   logic              reg_en = 1'b0;
   logic              reg_we = 1'b0;
   logic [11:0]       reg_addr = '0;
   logic [31:0]       reg_wdata = '0;
   logic [31:0]       reg_rdata;
   logic              irq;
   logic [NW-1:0]     win_pending;

   int n_run  = 0;
   int n_fail = 0;
   int cyc    = 0;
   logic done = 1'b0;

   always #4 clk = ~clk;

   mbx_rx_bank #(.NUM_WIN(NW), .IMPL_ID(IID), .ARCH_MAJOR(2), .ARCH_MINOR(1)) u_mbx_rx_bank (
      .clk(clk), .rst_n(rst_n), .link_set(link_set), .reg_en(reg_en), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
      .win_pending(win_pending)
   );

   // behavioural reference: status, mask and enable per the requirements
   logic [31:0] m_stat [NW];
   logic [31:0] m_mask [NW];
   logic        m_en;
   int          mw;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NW; i++) begin
            m_stat[i] = '0;
            m_mask[i] = '1;
         end
         m_en = 1'b0;
      end else begin
         if (reg_en && reg_we) begin
            mw = int'(reg_addr[11:5]);
            if (reg_addr < 12'hF80 && mw < NW) begin
               case (reg_addr[4:0])
                  5'h08:   m_stat[mw] = m_stat[mw] & ~reg_wdata;
                  5'h14:   m_mask[mw] = m_mask[mw] | reg_wdata;
                  5'h18:   m_mask[mw] = m_mask[mw] & ~reg_wdata;
                  default: ;
               endcase
            end else if (reg_addr == 12'hF98) begin
               m_en = reg_wdata[2];
            end
         end
         for (int i = 0; i < NW; i++) m_stat[i] = m_stat[i] | link_set[i*32 +: 32];
      end
   end

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   // per-cycle comparison of irq and summary against the model (R6, R7)
   always @(negedge clk) begin
      logic [NW-1:0] e_pend;
      logic          e_irq;
      cyc++;
      if (rst_n && !done) begin
         for (int i = 0; i < NW; i++) e_pend[i] = |(m_stat[i] & ~m_mask[i]);
         e_irq = m_en && (e_pend != '0);
         n_run++;
         if (irq !== e_irq || win_pending !== e_pend) begin
            n_fail++;
            $display("FAIL R6/R7 per-cycle: irq=%b exp %b pending=%h exp %h",
                     irq, e_irq, win_pending, e_pend);
         end
      end
      if (cyc > 150000 && !done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_en = 1'b0; reg_we = 1'b0;
   endtask

   task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
      @(negedge clk);
      reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
      @(negedge clk);
      reg_en = 1'b0;
      check(tag, reg_rdata, exp);
   endtask

   task automatic pulse(int w, logic [31:0] bits);
      @(negedge clk);
      link_set[w*32 +: 32] = bits;
      @(negedge clk);
      link_set = '0;
   endtask

   task automatic collide(int w, logic [31:0] bits);
      @(negedge clk);
      link_set[w*32 +: 32] = bits;
      reg_en = 1'b1; reg_we = 1'b1; reg_addr = 12'(w*32 + 8); reg_wdata = bits;
      @(negedge clk);
      link_set = '0; reg_en = 1'b0; reg_we = 1'b0;
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(12'h000, 32'h0, "R1 status after reset");
      rd(12'h010, 32'hFFFF_FFFF, "R1 mask after reset");
      rd(12'hF98, 32'h0, "R1 enable after reset");
      check("R1 irq after reset", {31'd0, irq}, 32'h0);

      // R9 identification
      rd(12'hF80, 32'd40, "R9 window count");
      rd(12'hFCC, 32'h21, "R9 revision");
      rd(12'hFC8, IID, "R9 implementer");

      // R2 set pulse while masked; R5 masked view
      pulse(0, 32'h5);
      rd(12'h000, 32'h5, "R2 status set by pulse");
      rd(12'h004, 32'h0, "R5 masked view fully masked");
      rd(12'hFA0, 32'h0, "R6 summary while masked");

      // R4 mask clear
      wr(12'h018, 32'h1);
      rd(12'h010, 32'hFFFF_FFFE, "R4 mask clear");
      rd(12'h004, 32'h1, "R5 masked view");
      rd(12'hFA0, 32'h1, "R6 summary window 0");
      check("R7 irq with enable off", {31'd0, irq}, 32'h0);

      // R7 enable
      wr(12'hF98, 32'h4);
      check("R7 irq enabled", {31'd0, irq}, 32'h1);
      rd(12'hF98, 32'h4, "R7 enable readback");

      // R3 partial clear, then last unmasked bit
      wr(12'h008, 32'h4);
      rd(12'h000, 32'h1, "R3 clear leaves zero-bit positions");
      check("R3 irq kept", {31'd0, irq}, 32'h1);
      wr(12'h008, 32'h1);
      check("R7 irq drops after clear", {31'd0, irq}, 32'h0);
      rd(12'h000, 32'h0, "R3 status cleared");

      // R6 window 35 lands in second summary word, bit 3
      pulse(35, 32'h8000_0000);
      wr(12'h478, 32'h8000_0000);
      check("R6 irq from window 35", {31'd0, irq}, 32'h1);
      check("R6 pending port bit 35", {31'd0, win_pending[35]}, 32'h1);
      rd(12'hFA4, 32'h8, "R6 summary word 1");
      rd(12'hFA0, 32'h0, "R6 summary word 0");

      // R8 set beats clear
      collide(35, 32'h8000_0000);
      rd(12'h460, 32'h8000_0000, "R8 collision on set bit");
      collide(1, 32'h1);
      rd(12'h020, 32'h1, "R8 collision on clear bit");

      // R4 mask set
      wr(12'h474, 32'h8000_0000);
      check("R4 irq after mask set", {31'd0, irq}, 32'h0);
      rd(12'h464, 32'h0, "R4 masked view after mask set");

      // R10 ignored and unimplemented
      wr(12'h020, 32'hFFFF_FFFF);
      rd(12'h020, 32'h1, "R10 write to status ignored");
      wr(12'h030, 32'h0);
      rd(12'h030, 32'hFFFF_FFFF, "R10 write to mask word ignored");
      rd(12'h02C, 32'h0, "R10 reserved slot offset");
      wr(12'h514, 32'hFFFF_FFFF);
      rd(12'h500, 32'h0, "R10 window beyond count");
      wr(12'hF84, 32'hFFFF_FFFF);
      rd(12'hF84, 32'h0, "R10 unused global");
      rd(12'hFB0, 32'h0, "R10 past summary");
      rd(12'hF98, 32'h4, "R10 enable untouched");

      // R11 read data holds
      rd(12'h460, 32'h8000_0000, "R11 read");
      repeat (3) @(negedge clk);
      check("R11 hold while idle", reg_rdata, 32'h8000_0000);
      wr(12'h468, 32'h8000_0000);
      check("R11 hold across write", reg_rdata, 32'h8000_0000);
      rd(12'h460, 32'h0, "R3 clear of window 35");

      repeat (4) @(negedge clk);
      done = 1'b1;
      finish_run();
   end
endmodule